// File: doc/BRIEF.md
# Reset Sequence Manager

This block gathers every reset cause on the chip into one internal reset for the core. It also drives the shared reset pin low through an open-drain pull-down. There are three causes: an external device pulls the pin low, a supply monitor reports a low-voltage condition, or the watchdog reports an underflow. Whatever the cause, the reset runs through the same three phases in the same order.

The first phase is an active phase. The pin is pulled low in this phase, and it lasts until the cause has gone away and a minimum pulse window has passed. The second phase is a stabilisation delay of 256 or 4096 clock cycles, chosen by a static option input, and the pin stays pulled low for all of it. The third phase is a two-cycle vector-fetch window: the pin is released, a fetch strobe is raised and the core is still held in reset. After that the core runs.

The external cause is captured without a clock, so the core enters reset even while its clock is stopped. The captured cause then passes through a synchronizer before it moves the sequencer. A new cause that arrives during the delay or fetch phase sends the sequence back to the active phase.

Top module: `rst_seq_ctrl`

## Requirements
- R1: `core_rst` is 1 whenever `rst_pin_pull` is 1 or `vec_fetch` is 1. It falls to 0 only after the fetch phase has ended.
- R2: While `lowv_req` is 1, `rst_pin_pull` and `core_rst` are both 1 and `vec_fetch` is 0, without waiting for a clock edge. When `lowv_req` is released, the pull stays on for MIN_PULSE+delay−1 further cycles.
- R3: The active phase ends only after MIN_PULSE consecutive clock edges (32 by default) with no request. A request that arrives during the active phase starts that count again.
- R4: The delay phase lasts 256 cycles when `long_dly_sel` is 0 and 4096 cycles when it is 1. `rst_pin_pull` stays 1 for the whole phase.
- R5: When the delay phase ends, `rst_pin_pull` goes to 0 and `vec_fetch` is 1 for exactly 2 cycles while `core_rst` stays 1. After that `core_rst` is 0.
- R6: A one-cycle `wdg_uflow` pulse while the core runs sets `rst_pin_pull` from the next edge. The pull then stays on for MIN_PULSE+delay cycles.
- R7: A low level on `rst_pin_in` while the block is not pulling the pin sets `core_rst` with no clock running. Once the clock runs, the request is synchronized and a full sequence follows.
- R8: A request during the delay or fetch phase restarts the sequence from the active phase. After a fetch-phase restart, `vec_fetch` falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_pin_in | input | 1 | Level read back from the reset pin (0 = low) |
| lowv_req | input | 1 | Low-voltage condition present (asynchronous, active high) |
| wdg_uflow | input | 1 | Watchdog underflow pulse, one clock wide |
| long_dly_sel | input | 1 | Static option: 0 selects the short delay, 1 the long delay |
| rst_pin_pull | output | 1 | Enables the open-drain pull-down on the reset pin |
| core_rst | output | 1 | Internal reset to the core, active high |
| vec_fetch | output | 1 | High during the two-cycle vector-fetch window |

## Verification
A wrong phase register or a miscounted counter changes the number of cycles `rst_pin_pull` stays high. The bench sees this on the cycle the pull should fall, within one delay span of the cause. A wrong fetch count changes the width of `vec_fetch` within three cycles, and a restart that is missed leaves the pull low too early. A broken asynchronous capture shows up at once as `core_rst` staying low while the clock is stopped.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

   typedef enum logic [1:0] {
      PH_ACTIVE = 2'd0,
      PH_DELAY  = 2'd1,
      PH_FETCH  = 2'd2,
      PH_RUN    = 2'd3
   } rsm_phase_e;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rsm_ext_capture.sv
module rsm_ext_capture #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic clr,
   input  logic pin_in,
   input  logic drive_low,
   output logic ext_pending,
   output logic ext_req
);

   logic ext_arst;
   logic [SYNC_STAGES-1:0] chain_q;

   if (SYNC_STAGES < 1) begin : g_bad_stages
      $error("rsm_ext_capture: SYNC_STAGES must be at least 1");
   end

   // The pin is only a request when this block is not the one pulling it low.
   assign ext_arst = ~pin_in & ~drive_low;

   always_ff @(posedge clk or posedge ext_arst) begin
      if (ext_arst)
         ext_pending <= 1'b1;
      else if (clr || chain_q[SYNC_STAGES-1])
         ext_pending <= 1'b0;
   end

   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
         if (clr) chain_q <= '0;
         else     chain_q <= ext_pending;
      end
   end else begin : g_many
      always_ff @(posedge clk) begin
         if (clr) chain_q <= '0;
         else     chain_q <= {chain_q[SYNC_STAGES-2:0], ext_pending};
      end
   end

   assign ext_req = chain_q[SYNC_STAGES-1];

   // R7
   sync_latency_chk: assert property (@(posedge clk) disable iff (clr)
      $rose(ext_req) |-> $past(ext_pending, SYNC_STAGES));

endmodule

// File: rtl/rsm_phase_fsm.sv
module rsm_phase_fsm
   import rsm_pkg::*;
#(
   parameter int unsigned MIN_PULSE = 32,
   parameter int unsigned SHORT_DLY = 256,
   parameter int unsigned LONG_DLY  = 4096,
   parameter int unsigned FETCH_LEN = 2,
   parameter int unsigned CNT_W     = 12
) (
   input  logic clk,
   input  logic lv_req,
   input  logic ext_req,
   input  logic wdg_uflow,
   input  logic long_dly,
   output logic pin_pull,
   output logic in_fetch,
   output logic running
);

   localparam logic [CNT_W-1:0] MIN_LAST   = CNT_W'(MIN_PULSE - 1);
   localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_DLY - 1);
   localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_DLY - 1);
   localparam logic [CNT_W-1:0] FETCH_LAST = CNT_W'(FETCH_LEN - 1);

   rsm_phase_e       ph_q, ph_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic             pull_q, pull_n;
   logic             req;
   logic [CNT_W-1:0] dly_last;

   assign req      = ext_req | wdg_uflow;
   assign dly_last = long_dly ? LONG_LAST : SHORT_LAST;

   always_comb begin
      ph_n  = ph_q;
      cnt_n = cnt_q;
      unique case (ph_q)
         PH_ACTIVE: begin
            if (req)                   cnt_n = '0;
            else if (cnt_q == MIN_LAST) begin ph_n = PH_DELAY; cnt_n = '0; end
            else                       cnt_n = cnt_q + 1'b1;
         end
         PH_DELAY: begin
            if (req)                   begin ph_n = PH_ACTIVE; cnt_n = '0; end
            else if (cnt_q == dly_last) begin ph_n = PH_FETCH; cnt_n = '0; end
            else                       cnt_n = cnt_q + 1'b1;
         end
         PH_FETCH: begin
            if (req)                   begin ph_n = PH_ACTIVE; cnt_n = '0; end
            else if (cnt_q == FETCH_LAST) begin ph_n = PH_RUN; cnt_n = '0; end
            else                       cnt_n = cnt_q + 1'b1;
         end
         default: begin
            if (req) begin ph_n = PH_ACTIVE; cnt_n = '0; end
         end
      endcase
      pull_n = (ph_n == PH_ACTIVE) || (ph_n == PH_DELAY);
   end

   always_ff @(posedge clk or posedge lv_req) begin
      if (lv_req) begin
         ph_q   <= PH_ACTIVE;
         cnt_q  <= '0;
         pull_q <= 1'b1;
      end else begin
         ph_q   <= ph_n;
         cnt_q  <= cnt_n;
         pull_q <= pull_n;
      end
   end

   assign pin_pull = pull_q;
   assign in_fetch = (ph_q == PH_FETCH);
   assign running  = (ph_q == PH_RUN);

   // R4
   dly_bound_chk: assert property (@(posedge clk) disable iff (lv_req)
      (ph_q == PH_DELAY) |-> (cnt_q <= dly_last));

   // R6
   wdg_entry_chk: assert property (@(posedge clk) disable iff (lv_req)
      (running && wdg_uflow) |=> (pin_pull && ph_q == PH_ACTIVE));

   // R8
   fetch_restart_chk: assert property (@(posedge clk) disable iff (lv_req)
      (in_fetch && req) |=> (ph_q == PH_ACTIVE && pin_pull));

   // R5
   release_to_fetch_chk: assert property (@(posedge clk) disable iff (lv_req)
      $fell(pin_pull) |-> in_fetch);

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
   import rsm_pkg::*;
#(
   parameter int unsigned MIN_PULSE   = 32,
   parameter int unsigned SHORT_DLY   = 256,
   parameter int unsigned LONG_DLY    = 4096,
   parameter int unsigned FETCH_LEN   = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_pin_in,
   input  logic lowv_req,
   input  logic wdg_uflow,
   input  logic long_dly_sel,
   output logic rst_pin_pull,
   output logic core_rst,
   output logic vec_fetch
);

   localparam int unsigned SPAN  = max_of(max_of(MIN_PULSE, LONG_DLY),
                                          max_of(SHORT_DLY, FETCH_LEN));
   localparam int unsigned CNT_W = (SPAN < 2) ? 1 : $clog2(SPAN);

   if (MIN_PULSE < 1 || FETCH_LEN < 1) begin : g_bad_len
      $error("rst_seq_ctrl: MIN_PULSE and FETCH_LEN must be at least 1");
   end
   if (SHORT_DLY < 1 || SHORT_DLY > LONG_DLY) begin : g_bad_dly
      $error("rst_seq_ctrl: need 1 <= SHORT_DLY <= LONG_DLY");
   end

   logic ext_pending, ext_req;
   logic in_fetch, running, pull;

   rsm_ext_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk         (clk),
      .clr         (lowv_req),
      .pin_in      (rst_pin_in),
      .drive_low   (pull),
      .ext_pending (ext_pending),
      .ext_req     (ext_req)
   );

   rsm_phase_fsm #(
      .MIN_PULSE (MIN_PULSE),
      .SHORT_DLY (SHORT_DLY),
      .LONG_DLY  (LONG_DLY),
      .FETCH_LEN (FETCH_LEN),
      .CNT_W     (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .lv_req    (lowv_req),
      .ext_req   (ext_req),
      .wdg_uflow (wdg_uflow),
      .long_dly  (long_dly_sel),
      .pin_pull  (pull),
      .in_fetch  (in_fetch),
      .running   (running)
   );

   assign rst_pin_pull = pull;
   assign vec_fetch    = in_fetch;
   assign core_rst     = ~running | ext_pending;

   // R1
   pull_holds_core_chk: assert property (@(posedge clk) disable iff (lowv_req)
      rst_pin_pull |-> core_rst);

   // R5
   fetch_in_rst_chk: assert property (@(posedge clk) disable iff (lowv_req)
      vec_fetch |-> (core_rst && !rst_pin_pull));

endmodule

// File: tb/rst_seq_ctrl_bench.sv
module rst_seq_ctrl_bench;

   localparam int MIN  = 32;
   localparam int SDLY = 256;
   localparam int LDLY = 4096;

   logic clk = 1'b0;
   logic clk_run = 1'b1;
   logic lv = 1'b0, wdg = 1'b0, ldly = 1'b0, ext_low = 1'b0;
   logic pin_in, pull, crst, fetch;
   int checks = 0, fails = 0;

   assign pin_in = ~(pull | ext_low);

   always begin
      #2;
      if (clk_run) clk = ~clk;
   end

   rst_seq_ctrl u_rst_seq_ctrl (
      .clk(clk), .rst_pin_in(pin_in), .lowv_req(lv), .wdg_uflow(wdg),
      .long_dly_sel(ldly), .rst_pin_pull(pull), .core_rst(crst), .vec_fetch(fetch)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   // Counts sampled cycles with the pull on, starting at the current negedge,
   // then checks the fetch window (R5) when asked.
   task automatic measure(input int lo, input int hi, input string rq, input bit do_fetch);
      int n = 0;
      bit core_ok = 1;
      while (pull && n < 20000) begin
         if (!crst) core_ok = 0;
         n++;
         @(negedge clk);
      end
      chk(n >= lo && n <= hi, rq, n, lo);
      chk(core_ok, "R1", int'(core_ok), 1);
      if (do_fetch) begin
         chk(fetch && crst, "R5", int'({fetch, crst}), 3);
         @(negedge clk);
         chk(fetch && crst && !pull, "R5", int'({fetch, crst, pull}), 6);
         @(negedge clk);
         chk(!fetch && !crst, "R5", int'({fetch, crst}), 0);
      end
   endtask

   task automatic wdg_pulse();
      @(negedge clk) wdg = 1'b1;
      @(negedge clk) wdg = 1'b0;
   endtask

   task automatic t_power_up();
      #1 lv = 1'b1;
      #1 chk(pull && crst && !fetch, "R2", int'({pull, crst, fetch}), 6);
      repeat (5) @(negedge clk);
      chk(pull && crst && !fetch, "R2", int'({pull, crst, fetch}), 6);
      lv = 1'b0;
      @(negedge clk);
      measure(MIN + SDLY - 1, MIN + SDLY - 1, "R2", 1);
   endtask

   task automatic t_wdg_short();
      wdg_pulse();
      chk(pull, "R6", int'(pull), 1);
      measure(MIN + SDLY, MIN + SDLY, "R6", 1);
   endtask

   task automatic t_long_delay();
      ldly = 1'b1;
      wdg_pulse();
      measure(MIN + LDLY, MIN + LDLY, "R4", 1);
      ldly = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_active_restart();
      wdg_pulse();
      repeat (10) @(negedge clk);
      wdg_pulse();
      measure(MIN + SDLY, MIN + SDLY, "R3", 1);
   endtask

   task automatic t_delay_restart();
      wdg_pulse();
      repeat (98) @(negedge clk);
      wdg_pulse();
      measure(MIN + SDLY, MIN + SDLY, "R8", 1);
   endtask

   task automatic t_fetch_restart();
      wdg_pulse();
      measure(MIN + SDLY, MIN + SDLY, "R6", 0);
      chk(fetch, "R8", int'(fetch), 1);
      wdg = 1'b1;
      @(negedge clk) wdg = 1'b0;
      chk(!fetch && pull, "R8", int'({fetch, pull}), 1);
      measure(MIN + SDLY, MIN + SDLY, "R8", 1);
   endtask

   task automatic t_lv_hold();
      bit held = 1;
      @(negedge clk) lv = 1'b1;
      #1 chk(pull && crst, "R2", int'({pull, crst}), 3);
      repeat (100) begin
         @(negedge clk);
         if (!pull || !crst || fetch) held = 0;
      end
      chk(held, "R2", int'(held), 1);
      lv = 1'b0;
      @(negedge clk);
      measure(MIN + SDLY - 1, MIN + SDLY - 1, "R2", 1);
   endtask

   task automatic t_ext_no_clock();
      int w = 0;
      @(negedge clk) clk_run = 1'b0;
      #6 ext_low = 1'b1;
      #5 chk(crst && !pull, "R7", int'({crst, pull}), 2);
      clk_run = 1'b1;
      while (!pull && w < 20) begin
         @(negedge clk);
         w++;
      end
      ext_low = 1'b0;
      // capture, synchronizer and flush add a few cycles on top of the window
      measure(MIN + SDLY, MIN + SDLY + 6, "R7", 1);
   endtask

   initial begin
      t_power_up();
      t_wdg_short();
      t_long_delay();
      t_active_restart();
      t_delay_restart();
      t_fetch_restart();
      t_lv_hold();
      t_ext_no_clock();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 60000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule